// File: doc/BRIEF.md
# Clock Failure Guard with Source Switchover

This block chooses the system clock source for a chip and protects it against a dead external reference. It drives three select lines: the free-running internal RC clock, the external reference clock, and a multiplied-clock path. The multiplier's own input can be taken from either the internal or the external clock. Software writes one small configuration word to enable monitoring, pick the multiplier input and request a source. The multiplied clock is represented here only by its ready flag; the oscillators and the multiplier are not part of the block.

The logic runs on the internal clock. A toggle flop clocked by the external reference is brought into the internal domain through a two-stage synchronizer. Each change of the synchronized toggle counts as one external rising edge. When monitoring is enabled and the external clock is in use, a counter measures internal cycles since the last such edge. If no edge arrives for the timeout, the block raises a sticky failure flag and a non-maskable interrupt request. It also moves the selection back to the internal clock on its own, so the system keeps running with no software action.

Every source change passes through a break-before-make gap in which all three select lines are low. Two select lines are therefore never high together.

Top module: `clkguard_top`

## Requirements
- R1: After reset, only `sel_int` is high, and `fail_flag`, `nmi_req` and `pll_src_ext` are low.
- R2: A source change first drops the old select on the clock edge after the target changes. All selects then stay low for GAP_CYC (default 2) cycles. The new select rises on the edge after that. With the defaults, the new select is visible three edges after the write edge, and selects never move directly from one source to another.
- R3: At most one of `sel_int`, `sel_ext` and `sel_pll` is high in any cycle.
- R4: The configuration word has the source code in bits [1:0] (0 internal, 1 external, 2 multiplied, 3 treated as internal). A multiplied-path request is honoured only while `pll_ready` is high. When `pll_ready` is low, or falls while that path is selected, the target is the internal clock.
- R5: When monitoring is enabled (bit 3 = 1) and the external clock is in use, a run of TIMEOUT (default 16) internal cycles with no synchronized external edge sets `fail_flag` and `nmi_req`. No failure is declared within 10 cycles after the external clock stops.
- R6: After a failure, the selection returns to `sel_int` through the R2 gap without any write.
- R7: `fail_flag` and `nmi_req` stay high until a write with the clear bit (bit 4) set. That write clears both on its write edge.
- R8: While `fail_flag` is high, writes that request the external or multiplied source leave the selection on the internal clock. After a clear, such a request is accepted again.
- R9: When the multiplier input is the external clock (bit 2 = 1) and the multiplied path is selected, a failure of the external clock deselects that path and returns to `sel_int`.
- R10: With monitoring disabled, or with the external clock unused (not requested, not selected, and not feeding a requested or selected multiplied path), a stopped external clock never sets `fail_flag`.
- R11: `pll_src_ext` follows bit 2 of the last write from the write edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running internal clock; all control logic runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External reference clock being monitored |
| pll_ready | input | 1 | Multiplied-clock path is locked and usable (synchronous to clk) |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 5 | [1:0] source code, [2] multiplier input external, [3] monitor enable, [4] clear failure |
| sel_int | output | 1 | Internal clock selected |
| sel_ext | output | 1 | External clock selected |
| sel_pll | output | 1 | Multiplied-clock path selected |
| pll_src_ext | output | 1 | Multiplier input select: 1 external, 0 internal |
| fail_flag | output | 1 | Sticky external-clock failure flag |
| nmi_req | output | 1 | Non-maskable interrupt request, held with the failure flag |

## Verification
The assertions assume three things. First, `pll_ready` and the configuration strobe are synchronous to the internal clock. Second, a write never lands on the same cycle that a failure is declared. Third, a running external clock toggles well inside the timeout, so a healthy source never trips the counter. The stimulus drives all inputs on the falling edge of the internal clock. It runs the external reference at three internal cycles per period and stops it only by holding it low. Writes are issued only while the failure state is settled, either long after the clock has stopped or with the flag already set.

// File: rtl/clkguard_pkg.sv
package clkguard_pkg;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2,
    SRC_RSV = 2'd3
  } src_e;

  // Select-line pattern for a source, ordered {pll, ext, int}.
  function automatic logic [2:0] src_onehot(src_e s);
    case (s)
      SRC_EXT: src_onehot = 3'b010;
      SRC_PLL: src_onehot = 3'b100;
      default: src_onehot = 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/clkguard_edge_mon.sv
module clkguard_edge_mon #(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  input  logic armed_i,
  output logic timeout_o
);
  localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  // Toggle flop in the external domain: flips once per rising edge.
  logic tog_q;
  always_ff @(posedge ext_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  // Synchronizer chain into the internal domain.
  logic [SYNC_STAGES-1:0] sync_q;
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= tog_q;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  logic last_q;
  logic edge_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[SYNC_STAGES-1];
  end
  assign edge_seen = sync_q[SYNC_STAGES-1] ^ last_q;

  // Cycles since the last observed edge, saturating at the limit.
  logic [CW-1:0] quiet_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      quiet_q <= '0;
    else if (!armed_i || edge_seen)  quiet_q <= '0;
    else if (quiet_q != LAST)        quiet_q <= quiet_q + 1'b1;
  end

  assign timeout_o = armed_i && !edge_seen && (quiet_q == LAST);

  // R10: a disarmed monitor restarts from zero and cannot time out next cycle
  p_disarm_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_i |=> quiet_q == '0);

endmodule

// File: rtl/clkguard_regs.sv
module clkguard_regs
  import clkguard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [4:0] cfg_wdata,
  input  logic       timeout_i,
  input  src_e       cur_i,
  input  logic       pll_ready,
  output src_e       tgt_o,
  output logic       armed_o,
  output logic       pll_src_ext_o,
  output logic       fail_o
);
  src_e req_q;
  logic mon_q;
  logic pll_ext_q;
  logic fail_q;
  src_e wr_src;

  always_comb begin
    wr_src = src_e'(cfg_wdata[1:0]);
    if (wr_src == SRC_RSV) wr_src = SRC_INT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q     <= SRC_INT;
      mon_q     <= 1'b0;
      pll_ext_q <= 1'b0;
      fail_q    <= 1'b0;
    end else if (timeout_i && !fail_q) begin
      fail_q <= 1'b1;
      req_q  <= SRC_INT;
    end else if (cfg_we) begin
      mon_q     <= cfg_wdata[3];
      pll_ext_q <= cfg_wdata[2];
      if (cfg_wdata[4]) fail_q <= 1'b0;
      if (!fail_q || wr_src == SRC_INT) req_q <= wr_src;
    end
  end

  // External clock counts as in use when it is, or feeds, a wanted or live source.
  logic ext_in_use;
  assign ext_in_use = (req_q == SRC_EXT) || (cur_i == SRC_EXT) ||
                      (pll_ext_q && ((req_q == SRC_PLL) || (cur_i == SRC_PLL)));
  assign armed_o = mon_q && ext_in_use;

  always_comb begin
    if (fail_q) begin
      tgt_o = SRC_INT;
    end else begin
      case (req_q)
        SRC_EXT: tgt_o = SRC_EXT;
        SRC_PLL: tgt_o = pll_ready ? SRC_PLL : SRC_INT;
        default: tgt_o = SRC_INT;
      endcase
    end
  end

  assign pll_src_ext_o = pll_ext_q;
  assign fail_o        = fail_q;

  // R7: the flag holds unless a clearing write arrives
  p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !(cfg_we && cfg_wdata[4])) |=> fail_q);

  // R8: external or multiplied requests during a failure leave the internal request
  p_ignore_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && cfg_we && (cfg_wdata[1:0] == 2'd1 || cfg_wdata[1:0] == 2'd2)) |=> req_q == SRC_INT);

  // R10: with the monitor disarmed, a clear flag stays clear
  p_no_fail_disarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_o && !fail_q) |=> !fail_q);

endmodule

// File: rtl/clkguard_switch.sv
module clkguard_switch
  import clkguard_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  src_e       tgt_i,
  input  logic       pll_ready,
  output src_e       cur_o,
  output logic [2:0] sel_o
);
  localparam int GW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  typedef enum logic {PH_RUN, PH_GAP} phase_e;

  phase_e        phase_q;
  src_e          cur_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      cur_q   <= SRC_INT;
      gap_q   <= '0;
    end else begin
      case (phase_q)
        PH_RUN: begin
          if (tgt_i != cur_q) begin
            phase_q <= PH_GAP;
            gap_q   <= '0;
          end
        end
        default: begin
          if (gap_q == GAP_LAST) begin
            phase_q <= PH_RUN;
            cur_q   <= tgt_i;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
      endcase
    end
  end

  assign cur_o = cur_q;
  assign sel_o = (phase_q == PH_RUN) ? src_onehot(cur_q) : 3'b000;

  // R3: never two sources live together
  p_onehot_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_o));

  // R2: a live select only ever follows nothing or itself
  p_break_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != 3'b000 && $past(sel_o) != 3'b000) |-> sel_o == $past(sel_o));

  // R4: losing the ready flag drops the multiplied path on the next edge
  p_pll_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o[2] && !pll_ready) |=> !sel_o[2]);

endmodule

// File: rtl/clkguard_top.sv
module clkguard_top
  import clkguard_pkg::*;
#(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2,
  parameter int GAP_CYC     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_clk,
  input  logic       pll_ready,
  input  logic       cfg_we,
  input  logic [4:0] cfg_wdata,
  output logic       sel_int,
  output logic       sel_ext,
  output logic       sel_pll,
  output logic       pll_src_ext,
  output logic       fail_flag,
  output logic       nmi_req
);
  logic       armed;
  logic       timeout;
  logic       fail;
  src_e       tgt;
  src_e       cur;
  logic [2:0] sel;

  clkguard_edge_mon #(.TIMEOUT(TIMEOUT), .SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_clk   (ext_clk),
    .armed_i   (armed),
    .timeout_o (timeout)
  );

  clkguard_regs u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_wdata     (cfg_wdata),
    .timeout_i     (timeout),
    .cur_i         (cur),
    .pll_ready     (pll_ready),
    .tgt_o         (tgt),
    .armed_o       (armed),
    .pll_src_ext_o (pll_src_ext),
    .fail_o        (fail)
  );

  clkguard_switch #(.GAP_CYC(GAP_CYC)) u_sw (
    .clk       (clk),
    .rst_n     (rst_n),
    .tgt_i     (tgt),
    .pll_ready (pll_ready),
    .cur_o     (cur),
    .sel_o     (sel)
  );

  assign sel_int   = sel[0];
  assign sel_ext   = sel[1];
  assign sel_pll   = sel[2];
  assign fail_flag = fail;
  assign nmi_req   = fail;

  // R6: once failed, the switch is steered to the internal clock
  p_fail_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> tgt == SRC_INT);

endmodule

// File: tb/clkguard_top_test.sv
module clkguard_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       ext_run = 1'b1;
  logic       pll_ready = 1'b0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic       sel_int, sel_ext, sel_pll, pll_src_ext, fail_flag, nmi_req;

  int checks = 0;
  int fails  = 0;

  localparam logic [2:0] S_INT = 3'b001, S_EXT = 3'b010, S_PLL = 3'b100, S_NONE = 3'b000;

  always #10 clk = ~clk;
  always #30 ext_clk = ext_run ? ~ext_clk : 1'b0;

  clkguard_top uut (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .pll_ready(pll_ready),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sel_int(sel_int), .sel_ext(sel_ext), .sel_pll(sel_pll),
    .pll_src_ext(pll_src_ext), .fail_flag(fail_flag), .nmi_req(nmi_req)
  );

  function automatic logic [2:0] sel_now();
    return {sel_pll, sel_ext, sel_int};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Write issued at a falling edge; returns at the falling edge after the write edge.
  task automatic write_cfg(logic [4:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 sel", 32'(sel_now()), 32'(S_INT));
    check("R1 fail", 32'(fail_flag), 0);
    check("R1 nmi", 32'(nmi_req), 0);
    check("R1 pll_src_ext", 32'(pll_src_ext), 0);
  endtask

  task automatic t_switch_ext();
    write_cfg(5'h09);
    check("R2 old select before gap", 32'(sel_now()), 32'(S_INT));
    wait_cyc(1);
    check("R2 gap cycle 1", 32'(sel_now()), 32'(S_NONE));
    wait_cyc(1);
    check("R2 gap cycle 2", 32'(sel_now()), 32'(S_NONE));
    wait_cyc(1);
    check("R2 R3 new select", 32'(sel_now()), 32'(S_EXT));
  endtask

  task automatic t_pll();
    pll_ready = 1'b0;
    write_cfg(5'h0A);
    wait_cyc(6);
    check("R4 not ready gives internal", 32'(sel_now()), 32'(S_INT));
    pll_ready = 1'b1;
    wait_cyc(6);
    check("R4 ready gives multiplied", 32'(sel_now()), 32'(S_PLL));
    pll_ready = 1'b0;
    wait_cyc(1);
    check("R4 ready loss drops path", 32'(sel_pll), 0);
    wait_cyc(5);
    check("R4 fallback on ready loss", 32'(sel_now()), 32'(S_INT));
    check("R10 no flag on ready loss", 32'(fail_flag), 0);
    write_cfg(5'h0E);
    check("R11 input select set", 32'(pll_src_ext), 1);
    write_cfg(5'h08);
    check("R11 input select cleared", 32'(pll_src_ext), 0);
    wait_cyc(6);
  endtask

  task automatic t_disarm();
    ext_run = 1'b0;
    wait_cyc(40);
    check("R10 unused clock no flag", 32'(fail_flag), 0);
    write_cfg(5'h01);
    wait_cyc(40);
    check("R10 monitor off selects ext", 32'(sel_now()), 32'(S_EXT));
    check("R10 monitor off no flag", 32'(fail_flag), 0);
    ext_run = 1'b1;
    wait_cyc(4);
    write_cfg(5'h08);
    wait_cyc(6);
    check("R10 back to internal", 32'(sel_now()), 32'(S_INT));
  endtask

  task automatic t_fail();
    write_cfg(5'h09);
    wait_cyc(10);
    check("R5 ext selected", 32'(sel_now()), 32'(S_EXT));
    ext_run = 1'b0;
    wait_cyc(10);
    check("R5 no early failure", 32'(fail_flag), 0);
    wait_cyc(30);
    check("R5 flag set", 32'(fail_flag), 1);
    check("R5 nmi set", 32'(nmi_req), 1);
    check("R6 automatic fallback", 32'(sel_now()), 32'(S_INT));
  endtask

  task automatic t_ignore_clear();
    write_cfg(5'h09);
    wait_cyc(8);
    check("R8 ext request ignored", 32'(sel_now()), 32'(S_INT));
    pll_ready = 1'b1;
    write_cfg(5'h0A);
    wait_cyc(8);
    check("R8 multiplied request ignored", 32'(sel_now()), 32'(S_INT));
    ext_run = 1'b1;
    wait_cyc(20);
    check("R7 flag sticky", 32'(fail_flag), 1);
    check("R7 nmi sticky", 32'(nmi_req), 1);
    write_cfg(5'h10);
    check("R7 flag cleared", 32'(fail_flag), 0);
    check("R7 nmi cleared", 32'(nmi_req), 0);
    write_cfg(5'h09);
    wait_cyc(3);
    check("R8 request accepted after clear", 32'(sel_now()), 32'(S_EXT));
  endtask

  task automatic t_pll_ext_fail();
    pll_ready = 1'b1;
    write_cfg(5'h0E);
    wait_cyc(6);
    check("R9 multiplied from ext", 32'(sel_now()), 32'(S_PLL));
    ext_run = 1'b0;
    wait_cyc(40);
    check("R9 failure flagged", 32'(fail_flag), 1);
    check("R9 multiplied path deselected", 32'(sel_now()), 32'(S_INT));
    ext_run = 1'b1;
    wait_cyc(4);
    write_cfg(5'h10);
    check("R9 cleared", 32'(fail_flag), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R1..all actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_switch_ext();
    t_pll();
    t_disarm();
    t_fail();
    t_ignore_clear();
    t_pll_ext_fail();
    wait_cyc(4);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule